// File: doc/BRIEF.md
# Indexed RTC Register File

This block is the host-facing register file of a real-time clock. The host reaches a 128-byte space through a two-port window. A write to the even port selects a byte by storing an index. An access to the odd port then reads or writes the selected byte. The block keeps the index latch and the byte storage. It applies the access rules of the four control and status bytes (indices 10 to 13), clears the interrupt flag byte when it is read, and loads the power-up defaults.

A neighbouring calendar block counts time. It loads new time bytes through a strobe, raises and drops the update-in-progress bit, and ORs interrupt flags into the flag byte. This block tells the calendar when host writes require the running time to be reloaded from the registers. It also exports the control bytes and the set-mode state.

Top module: `rtc_regfile_if`

## Requirements
- R1: A write to the even port (port select 0) stores the low 7 bits of the data as the current index. A read from the even port returns 0xFF.
- R2: An odd-port (port select 1) access reads or writes the byte at the current index. The alarm bytes (1, 3, 5) and indices 14 to 127 are plain storage with no side effects.
- R3: In control byte A (index 10), bit 7 (update in progress) cannot be written by the host. A host write replaces bits 6:0 and leaves bit 7 unchanged. uip_set_i sets bit 7 and uip_clr_i clears it.
- R4: A host write to control byte B (index 11) with bit 7 (set mode) high stores the value with bit 4 (update-ended enable) forced to 0. It also clears bit 7 of byte A. set_mode_o follows B bit 7.
- R5: Host writes to the flag byte C (index 12) and to byte D (index 13) have no effect.
- R6: An odd-port read of byte C returns its value and clears it to 0x00 at the clock edge. irq_o equals C bit 7, so it drops after that read.
- R7: Bits set through flag_set_i are ORed into byte C. When they arrive in the same cycle as a read of C, they survive the clear.
- R8: After reset, A=0x26, B=0x02, C=0x00, D=0x80, the index is 0 and every other byte is 0x00.
- R9: time_reload_o pulses for one cycle, in the cycle after the write, in two cases. The first is a host write to a time byte (0, 2, 4, 6, 7, 8, 9) while B bit 7 is 0. The second is a host write to B that clears bit 7 while it was 1. A time-byte write while B bit 7 is 1 gives no pulse.
- R10: cal_wr_i loads the seven time bytes from cal_time_i. Byte k of the vector (bits 8k+7:8k) goes, in order, to indices 0, 2, 4, 6, 7, 8 and 9. time_bytes_o shows those indices in the same packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Host access strobe, one cycle per access |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_port_i | input | 1 | 0 = index port, 1 = data port |
| acc_wdata_i | input | 8 | Host write data |
| acc_rdata_o | output | 8 | Host read data, valid in the access cycle |
| cal_wr_i | input | 1 | Calendar strobe that loads time bytes |
| cal_time_i | input | 56 | Time bytes from the calendar |
| uip_set_i | input | 1 | Set update-in-progress |
| uip_clr_i | input | 1 | Clear update-in-progress |
| flag_set_i | input | 8 | Flags ORed into byte C |
| time_bytes_o | output | 56 | Current time bytes to the calendar |
| ctrl_a_o | output | 8 | Control byte A |
| ctrl_b_o | output | 8 | Control byte B |
| set_mode_o | output | 1 | B bit 7 |
| time_reload_o | output | 1 | Reload-time request pulse |
| irq_o | output | 1 | Interrupt request (C bit 7) |

## Verification
Two collisions matter. A host read of byte C can land in the same cycle as an incoming flag. A host write to byte A can land in the same cycle as an update-in-progress change. The bench drives flag_set_i during a C read and expects the returned byte to be the old value and the stored byte to equal the new flags. Random reads with random flags repeat this against a bench model. For byte A, writes and uip strobes are checked in sequence, so that bit 7 tracks only the calendar inputs.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_TIME = 7;
  localparam int IDX_A    = 10;
  localparam int IDX_B    = 11;
  localparam int IDX_C    = 12;
  localparam int IDX_D    = 13;
  localparam int UIP_BIT  = 7;
  localparam int SET_BIT  = 7;
  localparam int UIE_BIT  = 4;
  localparam int IRQ_BIT  = 7;
  localparam logic [DATA_W-1:0] RST_A = 8'h26;
  localparam logic [DATA_W-1:0] RST_B = 8'h02;
  localparam logic [DATA_W-1:0] RST_C = 8'h00;
  localparam logic [DATA_W-1:0] RST_D = 8'h80;
  localparam logic [DATA_W-1:0] EVEN_RD = 8'hFF;

  // index -> time slot, -1 when not a time byte
  function automatic int slot_of(int idx);
    case (idx)
      0: return 0;
      2: return 1;
      4: return 2;
      6: return 3;
      7: return 4;
      8: return 5;
      9: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic int time_idx(int slot);
    case (slot)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 7;
      5: return 8;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_o <= '0;
    else if (ld_i) idx_o <= d_i;
  end

  a_r1_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> idx_o == $past(d_i));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_rf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              uip_set_i,
  input  logic              uip_clr_i,
  input  logic [DATA_W-1:0] flag_set_i,
  output logic [DATA_W-1:0] reg_a_o,
  output logic [DATA_W-1:0] reg_b_o,
  output logic [DATA_W-1:0] reg_c_o,
  output logic [DATA_W-1:0] reg_d_o,
  output logic              leave_set_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] I_A = ADDR_W'(IDX_A);
  localparam logic [ADDR_W-1:0] I_B = ADDR_W'(IDX_B);
  localparam logic [ADDR_W-1:0] I_C = ADDR_W'(IDX_C);

  logic wr_a, wr_b, rd_c;
  logic [DATA_W-1:0] a_n, b_n, c_n;

  assign wr_a = wr_i && (idx_i == I_A);
  assign wr_b = wr_i && (idx_i == I_B);
  assign rd_c = rd_i && (idx_i == I_C);

  always_comb begin
    a_n = reg_a_o;
    if (wr_a) a_n[UIP_BIT-1:0] = wdata_i[UIP_BIT-1:0];
    if (uip_set_i) a_n[UIP_BIT] = 1'b1;
    if (uip_clr_i) a_n[UIP_BIT] = 1'b0;
    if (wr_b && wdata_i[SET_BIT]) a_n[UIP_BIT] = 1'b0;

    b_n = reg_b_o;
    if (wr_b) begin
      b_n = wdata_i;
      if (wdata_i[SET_BIT]) b_n[UIE_BIT] = 1'b0;
    end

    // new flags win over the read clear
    c_n = (rd_c ? '0 : reg_c_o) | flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_o <= RST_A;
      reg_b_o <= RST_B;
      reg_c_o <= RST_C;
      reg_d_o <= RST_D;
    end else begin
      reg_a_o <= a_n;
      reg_b_o <= b_n;
      reg_c_o <= c_n;
      reg_d_o <= reg_d_o;
    end
  end

  assign leave_set_o = wr_b && !wdata_i[SET_BIT] && reg_b_o[SET_BIT];
  assign irq_o       = reg_c_o[IRQ_BIT];

  a_r3_uip_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a && !uip_set_i && !uip_clr_i) |=>
      (reg_a_o[UIP_BIT] == $past(reg_a_o[UIP_BIT])) &&
      (reg_a_o[UIP_BIT-1:0] == $past(wdata_i[UIP_BIT-1:0])));
  a_r4_set_kills_uie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b && wdata_i[SET_BIT]) |=> !reg_b_o[UIE_BIT] && !reg_a_o[UIP_BIT]);
  a_r5_c_not_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == I_C && flag_set_i == '0) |=> $stable(reg_c_o));
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && flag_set_i == '0) |=> reg_c_o == '0 && !irq_o);
  a_r7_flag_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_c |=> reg_c_o == $past(flag_set_i));
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
  import rtc_rf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         cal_wr_i,
  input  logic [NUM_TIME*DATA_W-1:0]   cal_time_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NUM_TIME*DATA_W-1:0]   time_bytes_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] mem_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int SLOT = slot_of(g);
    logic [DATA_W-1:0] q;
    logic hit;
    assign hit = wr_i && (idx_i == ADDR_W'(g));
    if (SLOT >= 0) begin : g_time
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (hit)      q <= wdata_i;
        else if (cal_wr_i) q <= cal_time_i[SLOT*DATA_W +: DATA_W];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wdata_i;
      end
    end
    assign mem_flat[g*DATA_W +: DATA_W] = q;
  end

  for (genvar k = 0; k < NUM_TIME; k++) begin : g_tout
    assign time_bytes_o[k*DATA_W +: DATA_W] = mem_flat[time_idx(k)*DATA_W +: DATA_W];
  end

  assign rdata_o = mem_flat[idx_i*DATA_W +: DATA_W];

  a_r2_write_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cal_wr_i) ##1 (idx_i == $past(idx_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/rtc_regfile_if.sv
module rtc_regfile_if
  import rtc_rf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_en_i,
  input  logic                       acc_we_i,
  input  logic                       acc_port_i,
  input  logic [7:0]                 acc_wdata_i,
  output logic [7:0]                 acc_rdata_o,
  input  logic                       cal_wr_i,
  input  logic [NUM_TIME*DATA_W-1:0] cal_time_i,
  input  logic                       uip_set_i,
  input  logic                       uip_clr_i,
  input  logic [7:0]                 flag_set_i,
  output logic [NUM_TIME*DATA_W-1:0] time_bytes_o,
  output logic [7:0]                 ctrl_a_o,
  output logic [7:0]                 ctrl_b_o,
  output logic                       set_mode_o,
  output logic                       time_reload_o,
  output logic                       irq_o
);
  logic [ADDR_W-1:0] idx;
  logic idx_ld, odd_wr, odd_rd, is_ctrl, is_time, leave_set, reload_q;
  logic [DATA_W-1:0] st_rdata, reg_a, reg_b, reg_c, reg_d, ctrl_rdata;

  assign idx_ld = acc_en_i &&  acc_we_i && !acc_port_i;
  assign odd_wr = acc_en_i &&  acc_we_i &&  acc_port_i;
  assign odd_rd = acc_en_i && !acc_we_i &&  acc_port_i;

  always_comb begin
    is_ctrl = (idx >= ADDR_W'(IDX_A)) && (idx <= ADDR_W'(IDX_D));
    is_time = slot_of(int'(idx)) >= 0;
    case (idx)
      ADDR_W'(IDX_A): ctrl_rdata = reg_a;
      ADDR_W'(IDX_B): ctrl_rdata = reg_b;
      ADDR_W'(IDX_C): ctrl_rdata = reg_c;
      default:        ctrl_rdata = reg_d;
    endcase
  end

  rtc_index_latch #(.ADDR_W(ADDR_W)) u_idx (
    .clk_i, .rst_ni, .ld_i(idx_ld), .d_i(acc_wdata_i[ADDR_W-1:0]), .idx_o(idx)
  );

  rtc_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(odd_wr), .rd_i(odd_rd), .idx_i(idx),
    .wdata_i(acc_wdata_i), .uip_set_i, .uip_clr_i, .flag_set_i,
    .reg_a_o(reg_a), .reg_b_o(reg_b), .reg_c_o(reg_c), .reg_d_o(reg_d),
    .leave_set_o(leave_set), .irq_o
  );

  rtc_byte_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni, .wr_i(odd_wr && !is_ctrl), .idx_i(idx), .wdata_i(acc_wdata_i),
    .cal_wr_i, .cal_time_i, .rdata_o(st_rdata), .time_bytes_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reload_q <= 1'b0;
    else         reload_q <= (odd_wr && is_time && !reg_b[SET_BIT]) || leave_set;
  end

  assign acc_rdata_o   = !acc_port_i ? EVEN_RD : (is_ctrl ? ctrl_rdata : st_rdata);
  assign ctrl_a_o      = reg_a;
  assign ctrl_b_o      = reg_b;
  assign set_mode_o    = reg_b[SET_BIT];
  assign time_reload_o = reload_q;

  a_r9_reload_on_time_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr && is_time && !set_mode_o) |=> time_reload_o);
  a_r9_no_reload_in_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr && is_time && set_mode_o) |=> !time_reload_o);
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_reload_o && !odd_wr) |=> !time_reload_o);
endmodule

// File: tb/sim_rtc_regfile_if.sv
module sim_rtc_regfile_if;
  import rtc_rf_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 0, acc_we = 0, acc_port = 0;
  logic [7:0] acc_wdata = '0, acc_rdata;
  logic cal_wr = 0;
  logic [55:0] cal_time = '0, time_bytes;
  logic uip_set = 0, uip_clr = 0;
  logic [7:0] flag_set = '0, ctrl_a, ctrl_b;
  logic set_mode, time_reload, irq;

  int checks = 0, fails = 0;
  logic [7:0] m [128];
  logic [6:0] cur_idx = '0;
  logic reload_seen;
  logic [7:0] fl = '0;

  always #10 clk = ~clk;

  rtc_regfile_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc_en), .acc_we_i(acc_we),
    .acc_port_i(acc_port), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .cal_wr_i(cal_wr), .cal_time_i(cal_time), .uip_set_i(uip_set), .uip_clr_i(uip_clr),
    .flag_set_i(flag_set), .time_bytes_o(time_bytes), .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b),
    .set_mode_o(set_mode), .time_reload_o(time_reload), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mdl_is_time(input int idx);
    return slot_of(idx) >= 0;
  endfunction

  // model a host data write, return expected reload pulse
  function automatic bit mdl_wr(input int idx, input logic [7:0] d_in);
    logic [7:0] d = d_in;
    bit r = 0;
    case (idx)
      10: m[10] = {m[10][7], d[6:0]};
      11: begin
        if (d[7]) begin m[10][7] = 1'b0; d[4] = 1'b0; end
        else if (m[11][7]) r = 1;
        m[11] = d;
      end
      12, 13: ;
      default: begin
        if (mdl_is_time(idx) && !m[11][7]) r = 1;
        m[idx] = d;
      end
    endcase
    return r;
  endfunction

  task automatic access(input bit we, input bit port, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    acc_en = 1; acc_we = we; acc_port = port; acc_wdata = d; flag_set = fl;
    #2 rd = acc_rdata;
    @(posedge clk);
    #1 reload_seen = time_reload;
    acc_en = 0; acc_we = 0; flag_set = '0;
  endtask

  task automatic do_idx(input logic [7:0] d);
    logic [7:0] rd;
    logic [7:0] f = fl;
    access(1, 0, d, rd);
    fl = '0;
    m[12] = m[12] | f;
    cur_idx = d[6:0];
  endtask

  task automatic do_wr(input logic [7:0] d, input string tag);
    logic [7:0] rd;
    logic [7:0] f = fl;
    bit er = mdl_wr(int'(cur_idx), d);
    access(1, 1, d, rd);
    fl = '0;
    m[12] = m[12] | f;
    chk(reload_seen == er, {tag, " R9 reload"}, reload_seen, er);
  endtask

  task automatic do_rd(input string tag);
    logic [7:0] rd;
    logic [7:0] f = fl;
    logic [7:0] e = m[cur_idx];
    access(0, 1, 8'h00, rd);
    fl = '0;
    chk(rd == e, tag, rd, e);
    if (cur_idx == 7'd12) m[12] = f; else m[12] = m[12] | f;
    chk(irq == m[12][7], "R6 irq", irq, m[12][7]);
  endtask

  task automatic rd_even();
    logic [7:0] rd;
    access(0, 0, 8'h00, rd);
    chk(rd == 8'hFF, "R1 even read", rd, 8'hFF);
  endtask

  task automatic pulse_uip(input bit set);
    @(negedge clk);
    if (set) uip_set = 1; else uip_clr = 1;
    @(posedge clk);
    #1 uip_set = 0; uip_clr = 0;
    m[10][7] = set;
  endtask

  task automatic cal_load(input logic [55:0] t);
    @(negedge clk);
    cal_wr = 1; cal_time = t;
    @(posedge clk);
    #1 cal_wr = 0;
    for (int k = 0; k < 7; k++) m[time_idx(k)] = t[k*8 +: 8];
  endtask

  function automatic logic [55:0] exp_time();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = m[time_idx(k)];
    return v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [55:0] tv;
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    m[10] = 8'h26; m[11] = 8'h02; m[13] = 8'h80;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R8 reset state
    chk(ctrl_a == 8'h26, "R8 reset A", ctrl_a, 8'h26);
    chk(ctrl_b == 8'h02, "R8 reset B", ctrl_b, 8'h02);
    chk(irq == 1'b0 && time_reload == 1'b0 && set_mode == 1'b0, "R8 reset outs",
        {irq, time_reload, set_mode}, 3'b000);
    do_rd("R8 index 0 byte");
    do_idx(8'd12); do_rd("R8 reset C");
    do_idx(8'd13); do_rd("R8 reset D");
    do_idx(8'd77); do_rd("R8 reset store");

    // R1 index uses low 7 bits, even read
    do_idx(8'h8A); do_rd("R1 index 0x8A selects A");
    rd_even();

    // R3 UIP read-only
    do_wr(8'hFF, "R3"); do_rd("R3 A write keeps UIP=0");
    pulse_uip(1); do_rd("R3 uip_set");
    do_wr(8'h00, "R3"); do_rd("R3 A write keeps UIP=1");
    pulse_uip(0); do_rd("R3 uip_clr");

    // R9 reload with SET=0
    do_idx(8'd0); do_wr(8'h30, "R9 sec write");
    // R4 SET forces UIE off, clears UIP
    pulse_uip(1);
    do_idx(8'd11); do_wr(8'h92, "R4");
    do_rd("R4 B stored with UIE off");
    chk(set_mode == 1'b1, "R4 set_mode_o", set_mode, 1'b1);
    do_idx(8'd10); do_rd("R4 UIP cleared");
    do_idx(8'd2); do_wr(8'h15, "R9 no reload in set mode");
    do_idx(8'd11); do_wr(8'h02, "R9 leave set mode");

    // R10 calendar load
    tv = 56'h24_12_31_07_23_59_58;
    cal_load(tv);
    chk(time_bytes == exp_time(), "R10 time_bytes_o", time_bytes, exp_time());
    do_idx(8'd4); do_rd("R10 hours byte");
    do_idx(8'd9); do_rd("R10 year byte");
    do_idx(8'd1); do_rd("R2 alarm untouched by load");

    // R5 writes to C and D ignored, R6 read-clear
    @(negedge clk) flag_set = 8'h90; @(posedge clk); #1 flag_set = '0;
    m[12] = 8'h90;
    chk(irq == 1'b1, "R6 irq raised", irq, 1'b1);
    do_idx(8'd12); do_wr(8'h00, "R5 C write");
    do_rd("R5 C unchanged / R6 read value");
    do_rd("R6 C cleared");
    do_idx(8'd13); do_wr(8'h00, "R5 D write"); do_rd("R5 D unchanged");

    // R7 flag in the same cycle as C read
    do_idx(8'd12);
    fl = 8'hC0; do_rd("R7 read during flag");
    chk(irq == 1'b1, "R7 flag survived clear", irq, 1'b1);
    do_rd("R7 C holds new flags");

    // R2 random mix against the model
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 2) do_idx(8'($urandom));
      else if (r < 6) do_wr(8'($urandom), "R2 random");
      else begin
        if (r == 9) fl = 8'($urandom);
        do_rd("R2 random read");
      end
    end
    chk(time_bytes == exp_time(), "R10 time_bytes_o end", time_bytes, exp_time());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule